// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a small synchronous up-counter with a parallel preset. It has an active-low clear, an active-low load that copies a data word into the count, and two active-high count enables. All state bits are registered together on the rising clock edge, so every output bit changes on the same edge and the outputs show no ripple glitches.

Two parameters choose the variant. `DECADE` picks the modulus: ten (count 0 to 9) or a full binary range (0 to 15 at the default width). `ASYNC_CLR` makes the clear act at once, without waiting for a clock edge, instead of acting on the next edge.

The carry output goes high when the count is at its terminal value and the carry-gating enable is high. Wider synchronous counters are built by chaining stages. Each stage's carry drives the next stage's carry-gating enable. The other enable is shared by all stages.

Top module: `sync_preset_counter`

## Requirements
- R1: A low `clr_n` sampled on a rising edge gives `q` = 0 after that edge, whatever the load, data and enable inputs are. When `clr_n` is high at the first edge after a clear, counting resumes from 0.
- R2: When `clr_n` is high and `load_n` is low at a rising edge, `q` takes the value of `din` after that edge, whatever `en_p` and `en_t` are.
- R3: Clear has priority over load. If `clr_n` and `load_n` are both low, the result is 0 and not `din`.
- R4: When `clr_n` and `load_n` are high, `q` advances by one on an edge only if `en_p` and `en_t` are both 1 at that edge. Otherwise `q` keeps its value.
- R5: On a counting edge where `q` equals the terminal value, `q` becomes 0. The terminal value is 9 when `DECADE`=1 and 2^`WIDTH`−1 when `DECADE`=0.
- R6: `carry` is 1 exactly when `en_t` is 1 and `q` equals the terminal value. `en_p` has no effect on `carry`.
- R7: With `DECADE`=1, a preset value from 10 to 15 increments by one on each counting edge, and 15 is followed by 0. `carry` stays 0 for these values.
- R8: Two 4-bit binary stages form an 8-bit counter when the low stage's `carry` drives the high stage's `en_t` and `en_p` is shared. The pair then counts modulo 256, including across the 0x0F→0x10 and 0xFF→0x00 boundaries.
- R9: With `ASYNC_CLR`=1, `q` becomes 0 as soon as `clr_n` goes low, with no clock edge. With `ASYNC_CLR`=0, `q` does not change until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear (async or sync by parameter) |
| load_n | input | 1 | Active-low synchronous parallel preset |
| din | input | WIDTH | Preset data |
| en_p | input | 1 | Count enable, does not gate the carry |
| en_t | input | 1 | Count enable, also gates the carry |
| q | output | WIDTH | Current count |
| carry | output | 1 | Terminal-count carry for cascading |

## Verification
The clocked properties assume that `clr_n` has been low on at least one edge before they start, because that clear is the only way the count becomes defined. The bench holds `clr_n` low for the first two cycles. After that it keeps clear rare, asserting it on about one cycle in sixteen. This leaves long runs of counting, loading and holding for the properties to observe. All inputs change half a period away from the rising edge, so the synchronous properties never see data changing at the edge. In the decade instance, `din` is drawn over the full 4-bit range on purpose, so that presets outside 0 to 9 are exercised.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

    typedef struct packed {
        cnt_op_e op;
        logic    carry_en;
    } cnt_ctl_t;

    function automatic int unsigned terminal_of(int unsigned width, bit decade);
        return decade ? 32'd9 : ((32'd1 << width) - 32'd1);
    endfunction

endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
    import cnt_pkg::*;
(
    input  logic     clr_n,
    input  logic     load_n,
    input  logic     en_p,
    input  logic     en_t,
    output cnt_ctl_t ctl
);
    // Priority: clear, load, count, hold (R3, R2, R4)
    always_comb begin
        ctl.carry_en = en_t;
        if (!clr_n)
            ctl.op = OP_CLEAR;
        else if (!load_n)
            ctl.op = OP_LOAD;
        else if (en_p && en_t)
            ctl.op = OP_COUNT;
        else
            ctl.op = OP_HOLD;
    end
endmodule

// File: rtl/cnt_next.sv
module cnt_next
    import cnt_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter logic [WIDTH-1:0] TERM = '1
) (
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);
    logic [WIDTH-1:0] inc;

    // Terminal wraps to zero; values above TERM roll through the full range
    assign inc = (cur == TERM) ? '0 : cur + WIDTH'(1);

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = din;
            OP_COUNT: nxt = inc;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/cnt_carry.sv
module cnt_carry #(
    parameter int unsigned WIDTH = 4,
    parameter logic [WIDTH-1:0] TERM = '1
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             carry_en,
    output logic             carry
);
    assign carry = carry_en && (cur == TERM);
endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
    import cnt_pkg::*;
#(
    parameter int unsigned WIDTH     = 4,
    parameter bit          DECADE    = 1'b0,
    parameter bit          ASYNC_CLR = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_p,
    input  logic             en_t,
    output logic [WIDTH-1:0] q,
    output logic             carry
);
    localparam logic [WIDTH-1:0] TERM = WIDTH'(terminal_of(WIDTH, DECADE));

    cnt_ctl_t         ctl;
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_d;

    cnt_ctrl u_ctrl (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (en_t),
        .ctl    (ctl)
    );

    cnt_next #(.WIDTH(WIDTH), .TERM(TERM)) u_next (
        .op  (ctl.op),
        .cur (cnt_q),
        .din (din),
        .nxt (cnt_d)
    );

    cnt_carry #(.WIDTH(WIDTH), .TERM(TERM)) u_carry (
        .cur      (cnt_q),
        .carry_en (ctl.carry_en),
        .carry    (carry)
    );

    generate
        if (ASYNC_CLR) begin : g_async_clr
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_d;
            end
        end else begin : g_sync_clr
            always_ff @(posedge clk) begin
                cnt_q <= cnt_d;
            end
        end
    endgenerate

    assign q = cnt_q;
endmodule

// File: rtl/sync_preset_counter_chk.sv
module sync_preset_counter_chk
    import cnt_pkg::*;
#(
    parameter int unsigned WIDTH  = 4,
    parameter bit          DECADE = 1'b0
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic [WIDTH-1:0] din,
    input logic             en_p,
    input logic             en_t,
    input logic [WIDTH-1:0] q,
    input logic             carry
);
    localparam logic [WIDTH-1:0] TERM = WIDTH'(terminal_of(WIDTH, DECADE));

    AST_CLEAR_ZERO: assert property (@(posedge clk)
        !clr_n |=> (q == '0));  // R1

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> (q == $past(din)));  // R2

    AST_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_p && en_t)) |=> (q == $past(q)));  // R4

    AST_STEP: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t && (q != TERM)) |=> (q == $past(q) + WIDTH'(1)));  // R4

    AST_WRAP: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && carry) |=> (q == '0));  // R5

    AST_CARRY_GATE: assert property (@(posedge clk) disable iff (!clr_n)
        !en_t |-> !carry);  // R6
endmodule

bind sync_preset_counter sync_preset_counter_chk #(
    .WIDTH  (WIDTH),
    .DECADE (DECADE)
) u_chk (
    .clk    (clk),
    .clr_n  (clr_n),
    .load_n (load_n),
    .din    (din),
    .en_p   (en_p),
    .en_t   (en_t),
    .q      (q),
    .carry  (carry)
);

// File: tb/sync_preset_counter_test.sv
`timescale 1ns/1ps
module sync_preset_counter_test;

    logic       clk = 1'b0;
    logic       clr_n = 1'b0, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
    logic [3:0] din = '0;
    logic       cas_en = 1'b0, cas_ld_n = 1'b1;
    logic [7:0] cas_din = '0;

    logic [3:0] q_b, q_d, q_a, q_lo, q_hi;
    logic       c_b, c_d, c_a, c_lo, c_hi;

    int errors = 0;
    int checks = 0;

    logic [3:0] m_b = '0, m_d = '0, m_a = '0;
    logic [7:0] m_cas = '0;

    always #2.5 clk = ~clk;

    sync_preset_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) uut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .en_p(en_p), .en_t(en_t), .q(q_b), .carry(c_b));

    sync_preset_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b0)) u_dec (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .en_p(en_p), .en_t(en_t), .q(q_d), .carry(c_d));

    sync_preset_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b1)) u_async (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .en_p(en_p), .en_t(en_t), .q(q_a), .carry(c_a));

    // R8: two-stage chain, low carry into high en_t, en_p shared
    sync_preset_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u_lo (
        .clk(clk), .clr_n(clr_n), .load_n(cas_ld_n), .din(cas_din[3:0]),
        .en_p(cas_en), .en_t(cas_en), .q(q_lo), .carry(c_lo));

    sync_preset_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u_hi (
        .clk(clk), .clr_n(clr_n), .load_n(cas_ld_n), .din(cas_din[7:4]),
        .en_p(cas_en), .en_t(c_lo), .q(q_hi), .carry(c_hi));

    function automatic logic [3:0] model_next(logic [3:0] cur, logic term4, logic cl, logic ld,
                                              logic [3:0] d, logic ep, logic et);
        logic [3:0] t;
        t = term4 ? 4'd9 : 4'd15;
        if (!cl) return 4'd0;
        if (!ld) return d;
        if (ep && et) return (cur == t) ? 4'd0 : cur + 4'd1;
        return cur;
    endfunction

    function automatic logic model_carry(logic [3:0] cur, logic dec, logic et);
        return et && (cur == (dec ? 4'd9 : 4'd15));
    endfunction

    function automatic logic [7:0] model_cas(logic [7:0] cur, logic cl, logic ld,
                                             logic [7:0] d, logic en);
        if (!cl) return 8'd0;
        if (!ld) return d;
        if (en) return cur + 8'd1;
        return cur;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive at negedge, check carry, let one rising edge pass, check q at next negedge
    task automatic cycle(logic cl, logic ld, logic [3:0] d, logic ep, logic et,
                         logic ce, logic cld, logic [7:0] cd, string tag);
        clr_n = cl; load_n = ld; din = d; en_p = ep; en_t = et;
        cas_en = ce; cas_ld_n = cld; cas_din = cd;
        if (!cl) m_a = 4'd0;  // R9 async variant clears at once
        #1;
        check({tag, "/R6 carry bin"}, {7'd0, c_b}, {7'd0, model_carry(m_b, 1'b0, et)});
        check({tag, "/R6 carry dec"}, {7'd0, c_d}, {7'd0, model_carry(m_d, 1'b1, et)});
        check({tag, "/R6 carry async"}, {7'd0, c_a}, {7'd0, model_carry(m_a, 1'b0, et)});
        check({tag, "/R8 carry chain"}, {7'd0, c_hi}, {7'd0, ce && (m_cas == 8'hFF)});
        @(posedge clk);
        m_b = model_next(m_b, 1'b0, cl, ld, d, ep, et);
        m_d = model_next(m_d, 1'b1, cl, ld, d, ep, et);
        m_a = model_next(m_a, 1'b0, cl, ld, d, ep, et);
        m_cas = model_cas(m_cas, cl, cld, cd, ce);
        @(negedge clk);
        check({tag, " q bin"}, {4'd0, q_b}, {4'd0, m_b});
        check({tag, " q dec"}, {4'd0, q_d}, {4'd0, m_d});
        check({tag, " q async"}, {4'd0, q_a}, {4'd0, m_a});
        check({tag, "/R8 q chain"}, {q_hi, q_lo}, m_cas);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        // R1 reset state
        cycle(0, 1, 4'd0, 0, 0, 0, 1, 8'd0, "R1 reset");
        cycle(0, 1, 4'd0, 0, 0, 0, 1, 8'd0, "R1 reset");
        // R2 load with enables low and high
        cycle(1, 0, 4'd14, 0, 0, 0, 0, 8'h0E, "R2 load");
        cycle(1, 0, 4'd7, 1, 1, 0, 1, 8'h0E, "R2 load en");
        cycle(1, 0, 4'd14, 1, 0, 1, 1, 8'h0E, "R4 count");
        // R4 single-enable holds
        cycle(1, 1, 4'd3, 1, 0, 1, 1, 8'h00, "R4 hold ep");
        cycle(1, 1, 4'd3, 0, 1, 1, 1, 8'h00, "R4 hold et");
        cycle(1, 1, 4'd3, 1, 1, 1, 1, 8'h00, "R4 step");
        // R6 carry at terminal with en_t low / en_p low
        cycle(1, 1, 4'd0, 1, 0, 0, 1, 8'h00, "R6 gate");
        cycle(1, 1, 4'd0, 0, 1, 0, 1, 8'h00, "R6 enp");
        // R5 wrap
        cycle(1, 1, 4'd0, 1, 1, 0, 1, 8'h00, "R5 wrap");
        // R7 decade out-of-range presets
        cycle(1, 0, 4'd9, 0, 1, 0, 0, 8'hFE, "R7 load9");
        cycle(1, 1, 4'd0, 1, 1, 1, 1, 8'h00, "R5 dec wrap");
        cycle(1, 0, 4'd12, 0, 0, 1, 1, 8'h00, "R7 load12");
        for (int i = 0; i < 4; i++)
            cycle(1, 1, 4'd0, 1, 1, 1, 1, 8'h00, "R7 roll");
        // R3 clear beats load
        cycle(0, 0, 4'd5, 1, 1, 0, 0, 8'h55, "R3 clr>load");
        // R9 clear without a clock edge
        cycle(1, 0, 4'd6, 0, 0, 0, 1, 8'h00, "R9 setup");
        #1 clr_n = 1'b0;
        #1;
        check("R9 async immediate", {4'd0, q_a}, 8'd0);
        check("R9 sync waits", {4'd0, q_b}, 8'd6);
        cycle(0, 1, 4'd0, 0, 0, 0, 1, 8'd0, "R9 after");
        // R8 directed chain boundaries
        cycle(1, 1, 4'd0, 0, 0, 0, 0, 8'h0E, "R8 load0E");
        for (int i = 0; i < 3; i++) cycle(1, 1, 4'd0, 0, 0, 1, 1, 8'h00, "R8 cross");
        cycle(1, 1, 4'd0, 0, 0, 0, 0, 8'hFE, "R8 loadFE");
        for (int i = 0; i < 3; i++) cycle(1, 1, 4'd0, 0, 0, 1, 1, 8'h00, "R8 wrap");
        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            cycle(($urandom % 16) != 0, ($urandom % 8) != 0, 4'($urandom),
                  ($urandom % 4) != 0, ($urandom % 4) != 0,
                  ($urandom % 4) != 0, ($urandom % 32) != 0, 8'($urandom), "rand");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule